// File: doc/BRIEF.md
# Sample Window Stop-Timing Controller

This block opens and closes the tracking window of two sample-and-hold channels. A channel's window opens when its trigger input rises. It closes in one of three ways, chosen by a shared 4-bit stop code and a clock-select bit:

- when the trigger falls;
- after a fixed number of system-clock cycles;
- after a counted number of rising edges of an external clock.

The external clock is brought into the system clock domain before it is counted. Each channel drives a level output that is high while it tracks. It also drives a one-cycle strobe that marks the start of its hold phase.

The stop code and the clock select are taken when a window opens and held until it closes. Each channel also has an arm bit. While the arm bit is low, that channel ignores its trigger.

The system clock is assumed to run at 20 MHz. At that rate the timed codes give 300 ns to 5 µs. The trigger inputs are synchronous to the system clock.

Top module: `sh_window_ctrl`

## Requirements
- R1: While `rst_n` is low and after it is released, `sample_o` and `done_o` are 0 until a trigger rises on an armed channel.
- R2: A channel whose arm bit is 1 raises `sample_o` in the cycle after the first system-clock edge that sees its trigger high, where the previous edge saw it low.
- R3: Stop code 0 closes the window on the trigger's falling edge, with either clock select. A trigger that is high for H cycles gives a window of exactly H cycles.
- R4: With `ext_sel` = 0, stop codes 4 to 15 give windows of 6, 7, 9, 11, 15, 20, 30, 35, 40, 50, 80 and 100 cycles, in code order. These are 300 ns to 5 µs at 50 ns per cycle.
- R5: With `ext_sel` = 0, stop codes 1, 2 and 3 behave like code 0.
- R6: With `ext_sel` = 1, stop code n (1 to 15) closes the window on the (20+n)-th synchronised rising edge of `ext_clk` seen after the window opens. Each edge reaches the counter at the third system-clock edge after it.
- R7: In a timed mode, a trigger that falls before the count ends does not shorten the window.
- R8: A new rising trigger edge while that channel's window is open neither restarts nor extends it.
- R9: `done_o` of a channel is high for exactly one cycle: the first cycle in which that channel's `sample_o` is low again. It is never high at any other time.
- R10: A channel whose arm bit is 0 ignores trigger edges, and its `sample_o` stays 0.
- R11: The stop code and the clock select are sampled when the window opens. Changing them while it is open does not change its length.
- R12: The two channels run independently, and each can have a window open at the same time as the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (20 MHz assumed) |
| rst_n | input | 1 | Synchronous active-low reset |
| stop_code | input | 4 | Shared stop-control code |
| ext_sel | input | 1 | 1: timed codes count external clock edges; 0: system-clock cycles |
| ch_arm | input | 2 | Per-channel arm bit; bit 0 is channel 0 |
| trig | input | 2 | Per-channel trigger pulse; bit 0 is channel 0 |
| ext_clk | input | 1 | External counting clock, asynchronous |
| sample_o | output | 2 | High while the channel tracks |
| done_o | output | 2 | One-cycle hold-start strobe per channel |

## Verification
The assertions assume the following of the inputs:
- The triggers and arm bits are synchronous to the system clock.
- A trigger stays low at least one cycle between pulses.
- The external clock changes slowly enough that every rising edge survives synchronisation as its own one-cycle pulse.

The stimulus meets these assumptions in three ways. It changes every input on the falling system-clock edge. It toggles the external clock every three system cycles. It starts each externally timed pulse on a rising edge of that clock, which makes the expected window lengths exact.

// File: rtl/sh_win_pkg.sv
// Package: shared types and the stop-code timing table for the sample
// window controller. Assumes a 20 MHz system clock (50 ns per cycle).
package sh_win_pkg;

    typedef enum logic [1:0] {
        W_IDLE = 2'd0,
        W_EDGE = 2'd1,
        W_INT  = 2'd2,
        W_EXT  = 2'd3
    } win_st_t;

    // Cycle count of each internal-clock timed code; 0 means untimed.
    function automatic int int_cycles(input logic [3:0] code);
        case (code)
            4'd4:    return 6;
            4'd5:    return 7;
            4'd6:    return 9;
            4'd7:    return 11;
            4'd8:    return 15;
            4'd9:    return 20;
            4'd10:   return 30;
            4'd11:   return 35;
            4'd12:   return 40;
            4'd13:   return 50;
            4'd14:   return 80;
            4'd15:   return 100;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/sh_ext_edge.sv
// Module: brings the asynchronous external clock into the system clock
// domain through SYNC_STAGES flops and emits a one-cycle tick for each
// rising edge. Assumes the external clock's high and low phases are each
// longer than two system cycles.
module sh_ext_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_clk,
    output logic tick_o
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   last_q;

    // Synchroniser chain and previous-value flop for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], ext_clk};
            last_q <= sync_q[SYNC_STAGES-1];
        end
    end

    // Rising edge of the synchronised level.
    always_comb tick_o = sync_q[SYNC_STAGES-1] & ~last_q;

endmodule

// File: rtl/sh_stop_decode.sv
// Module: turns the stop code and clock select into a close mode and a
// count limit. Code 0, and codes below 4 on the internal clock, mean
// "close on trigger fall". Purely combinational.
module sh_stop_decode #(
    parameter int LIM_W    = 7,
    parameter int EXT_BASE = 20
) (
    input  logic [3:0]       code_i,
    input  logic             ext_sel_i,
    output logic             timed_o,
    output logic             use_ext_o,
    output logic [LIM_W-1:0] limit_o
);
    import sh_win_pkg::*;

    localparam logic [3:0] FIRST_INT_CODE = 4'd4;

    // Select mode and limit for the requested code.
    always_comb begin
        use_ext_o = ext_sel_i;
        if (ext_sel_i) begin
            timed_o = (code_i != 4'd0);
            limit_o = LIM_W'(EXT_BASE) + LIM_W'(code_i);
        end else begin
            timed_o = (code_i >= FIRST_INT_CODE);
            limit_o = LIM_W'(int_cycles(code_i));
        end
    end

endmodule

// File: rtl/sh_channel.sv
// Module: window state machine for one sample-and-hold channel. It opens
// on a rising trigger edge while armed, then closes on trigger fall, after
// a cycle count, or after a count of external ticks. The mode is latched at
// the opening edge. Assumes the trigger is synchronous to clk.
module sh_channel #(
    parameter int LIM_W    = 7,
    parameter int EXT_BASE = 20
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       trig_i,
    input  logic       arm_i,
    input  logic [3:0] code_i,
    input  logic       ext_sel_i,
    input  logic       ext_tick_i,
    output logic       sample_o,
    output logic       done_o
);
    import sh_win_pkg::*;

    win_st_t          st_q;
    logic             trig_q;
    logic             rise;
    logic [LIM_W-1:0] cnt_q;
    logic [LIM_W-1:0] lim_q;
    logic             dec_timed;
    logic             dec_ext;
    logic [LIM_W-1:0] dec_lim;
    logic             last_count;

    sh_stop_decode #(
        .LIM_W    (LIM_W),
        .EXT_BASE (EXT_BASE)
    ) u_dec (
        .code_i    (code_i),
        .ext_sel_i (ext_sel_i),
        .timed_o   (dec_timed),
        .use_ext_o (dec_ext),
        .limit_o   (dec_lim)
    );

    // Previous trigger level for rising-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) trig_q <= 1'b0;
        else        trig_q <= trig_i;
    end

    always_comb rise       = trig_i & ~trig_q;
    always_comb last_count = (cnt_q == lim_q - LIM_W'(1));

    // Window state, counter and hold-start strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= W_IDLE;
            cnt_q  <= '0;
            lim_q  <= '0;
            done_o <= 1'b0;
        end else begin
            done_o <= 1'b0;
            case (st_q)
                W_IDLE: begin
                    if (rise && arm_i) begin
                        cnt_q <= '0;
                        lim_q <= dec_lim;
                        if (!dec_timed)   st_q <= W_EDGE;
                        else if (dec_ext) st_q <= W_EXT;
                        else              st_q <= W_INT;
                    end
                end
                W_EDGE: begin
                    if (!trig_i) begin
                        st_q   <= W_IDLE;
                        done_o <= 1'b1;
                    end
                end
                W_INT: begin
                    if (last_count) begin
                        st_q   <= W_IDLE;
                        done_o <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q + LIM_W'(1);
                    end
                end
                W_EXT: begin
                    if (ext_tick_i) begin
                        if (last_count) begin
                            st_q   <= W_IDLE;
                            done_o <= 1'b1;
                        end else begin
                            cnt_q <= cnt_q + LIM_W'(1);
                        end
                    end
                end
                default: st_q <= W_IDLE;
            endcase
        end
    end

    // Tracking while any window state is active.
    always_comb sample_o = (st_q != W_IDLE);

endmodule

// File: rtl/sh_window_ctrl.sv
// Module: top of the sample window controller. It shares one external
// clock synchroniser and one set of control fields between N_CH channel
// state machines. Assumes a 20 MHz clk and triggers synchronous to it.
module sh_window_ctrl #(
    parameter int N_CH        = 2,
    parameter int LIM_W       = 7,
    parameter int EXT_BASE    = 20,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [3:0]      stop_code,
    input  logic            ext_sel,
    input  logic [N_CH-1:0] ch_arm,
    input  logic [N_CH-1:0] trig,
    input  logic            ext_clk,
    output logic [N_CH-1:0] sample_o,
    output logic [N_CH-1:0] done_o
);
    logic ext_tick;

    sh_ext_edge #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_ext (
        .clk     (clk),
        .rst_n   (rst_n),
        .ext_clk (ext_clk),
        .tick_o  (ext_tick)
    );

    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        sh_channel #(
            .LIM_W    (LIM_W),
            .EXT_BASE (EXT_BASE)
        ) u_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .trig_i     (trig[g]),
            .arm_i      (ch_arm[g]),
            .code_i     (stop_code),
            .ext_sel_i  (ext_sel),
            .ext_tick_i (ext_tick),
            .sample_o   (sample_o[g]),
            .done_o     (done_o[g])
        );
    end

endmodule

// File: rtl/sh_window_ctrl_chk.sv
// Checker: port-level properties of the sample window controller, bound to
// every instance of the top module.
module sh_window_ctrl_chk #(
    parameter int N_CH = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic [N_CH-1:0] ch_arm,
    input logic [N_CH-1:0] trig,
    input logic [N_CH-1:0] sample_o,
    input logic [N_CH-1:0] done_o
);
    for (genvar g = 0; g < N_CH; g++) begin : g_chk
        // R2: a window only opens after a high trigger on an armed channel
        a_r2_open_needs_trigger: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(sample_o[g]) |-> ($past(trig[g]) && $past(ch_arm[g])));

        // R9: the end of every window raises the strobe
        a_r9_done_on_close: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(sample_o[g]) |-> done_o[g]);

        // R9: the strobe appears only in the first cycle after a close
        a_r9_done_only_after_close: assert property (@(posedge clk) disable iff (!rst_n)
            done_o[g] |-> (!sample_o[g] && $past(sample_o[g])));

        // R9: the strobe lasts a single cycle
        a_r9_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
            done_o[g] |=> !done_o[g]);

        // R10: an idle, unarmed channel stays idle
        a_r10_unarmed_idle: assert property (@(posedge clk) disable iff (!rst_n)
            (!ch_arm[g] && !sample_o[g]) |=> !sample_o[g]);
    end
endmodule

bind sh_window_ctrl sh_window_ctrl_chk #(.N_CH(N_CH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ch_arm   (ch_arm),
    .trig     (trig),
    .sample_o (sample_o),
    .done_o   (done_o)
);

// File: tb/sh_window_ctrl_bench.sv
module sh_window_ctrl_bench;
    localparam int CLK_PERIOD = 50;

    typedef struct {
        int    len;
        string tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [3:0] stop_code;
    logic       ext_sel;
    logic [1:0] ch_arm;
    logic [1:0] trig;
    logic       ext_clk = 1'b0;
    logic [1:0] sample_o;
    logic [1:0] done_o;

    int   checks = 0;
    int   fails  = 0;
    int   ext_ph = 0;
    int   run_len [2];
    logic prev_s  [2];
    exp_t q0[$];
    exp_t q1[$];
    exp_t e;
    bit   have;
    bit   ch0_seen;

    sh_window_ctrl u_sh_window_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .stop_code (stop_code),
        .ext_sel   (ext_sel),
        .ch_arm    (ch_arm),
        .trig      (trig),
        .ext_clk   (ext_clk),
        .sample_o  (sample_o),
        .done_o    (done_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // External clock: period of six system cycles, changed on falling edges.
    always @(negedge clk) begin
        ext_clk <= (ext_ph >= 3);
        ext_ph  <= (ext_ph == 5) ? 0 : ext_ph + 1;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    task automatic push(input int ch, input int len, input string tag);
        exp_t x;
        x.len = len;
        x.tag = tag;
        if (ch == 0) q0.push_back(x);
        else         q1.push_back(x);
    endtask

    task automatic pulse(input int ch, input int h);
        @(negedge clk);
        trig[ch] = 1'b1;
        repeat (h) @(negedge clk);
        trig[ch] = 1'b0;
    endtask

    task automatic pulse_ext(input int ch, input int h);
        @(posedge ext_clk);
        trig[ch] = 1'b1;
        repeat (h) @(negedge clk);
        trig[ch] = 1'b0;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: measure each window and compare with the scoreboard.
    always @(negedge clk) begin
        if (rst_n) begin
            for (int c = 0; c < 2; c++) begin
                if (sample_o[c]) begin
                    run_len[c]++;
                    if (c == 0) ch0_seen = 1'b1;
                end else if (prev_s[c]) begin
                    chk(done_o[c] == 1'b1, "R9 strobe at close", int'(done_o[c]), 1);
                    have = 1'b0;
                    if (c == 0 && q0.size() > 0) begin e = q0.pop_front(); have = 1'b1; end
                    if (c == 1 && q1.size() > 0) begin e = q1.pop_front(); have = 1'b1; end
                    if (have) chk(run_len[c] == e.len, e.tag, run_len[c], e.len);
                    else      chk(1'b0, "R10/R8 unexpected window", run_len[c], 0);
                    run_len[c] = 0;
                end else if (done_o[c]) begin
                    chk(1'b0, "R9 stray strobe", 1, 0);
                end
                prev_s[c] = sample_o[c];
            end
        end
    end

    // Watchdog.
    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        int ns_tab [12] = '{300, 350, 450, 550, 750, 1000, 1500, 1750, 2000, 2500, 4000, 5000};
        run_len[0] = 0; run_len[1] = 0;
        prev_s[0] = 1'b0; prev_s[1] = 1'b0;
        rst_n = 1'b0; stop_code = 4'd0; ext_sel = 1'b0; ch_arm = 2'b00; trig = 2'b00;
        settle(5);
        chk(sample_o == 2'b00 && done_o == 2'b00, "R1 reset quiet", int'({sample_o, done_o}), 0);
        rst_n = 1'b1;
        settle(3);
        chk(sample_o == 2'b00 && done_o == 2'b00, "R1 after release", int'({sample_o, done_o}), 0);
        ch_arm = 2'b11;

        // R2, R3: close on trigger fall, internal select
        push(0, 5, "R2/R3 fall close H=5"); pulse(0, 5); settle(4);
        push(0, 1, "R2/R3 fall close H=1"); pulse(0, 1); settle(4);

        // R4, R7: timed internal codes with a short trigger
        for (int c = 4; c < 16; c++) begin
            stop_code = 4'(c);
            push(0, ns_tab[c-4] / 50, $sformatf("R4/R7 internal code %0d", c));
            pulse(0, 2);
            settle(ns_tab[c-4] / 50 + 4);
        end

        // R5: reserved internal codes act like code 0
        for (int c = 1; c < 4; c++) begin
            stop_code = 4'(c);
            push(1, 4, $sformatf("R5 reserved code %0d", c));
            pulse(1, 4); settle(4);
        end

        // R3: code 0 with the external select
        ext_sel = 1'b1; stop_code = 4'd0;
        push(1, 7, "R3 fall close ext select"); pulse(1, 7); settle(4);

        // R6: external edge counts, trigger aligned to an external rising edge
        foreach (ns_tab[k]) begin
            if (k < 4) begin
                int c;
                c = (k == 0) ? 1 : (k == 1) ? 2 : (k == 2) ? 8 : 15;
                stop_code = 4'(c);
                push(0, 6 * (20 + c) - 4, $sformatf("R6 external code %0d", c));
                pulse_ext(0, 3);
                settle(6 * (20 + c) + 4);
            end
        end

        // R8: second rising edge during an open window
        ext_sel = 1'b0; stop_code = 4'd15;
        push(1, 100, "R8 retrigger ignored");
        pulse(1, 2); settle(10); pulse(1, 2); settle(100);

        // R11: control change during an open window
        stop_code = 4'd8;
        push(0, 15, "R11 latched at open");
        pulse(0, 2); settle(3); stop_code = 4'd0; ext_sel = 1'b1;
        settle(20);
        ext_sel = 1'b0;

        // R10: unarmed channel 0, armed channel 1 alongside
        ch_arm = 2'b10; stop_code = 4'd0; ch0_seen = 1'b0;
        push(1, 4, "R10 armed neighbour");
        fork
            pulse(0, 4);
            pulse(1, 4);
        join
        settle(6);
        chk(ch0_seen == 1'b0, "R10 unarmed stays low", int'(ch0_seen), 0);
        ch_arm = 2'b11;

        // R12: overlapping windows on both channels
        push(0, 5, "R12 channel 0 overlap");
        push(1, 12, "R12 channel 1 overlap");
        fork
            pulse(0, 5);
            pulse(1, 12);
        join
        settle(6);

        chk(q0.size() == 0, "R12 channel 0 windows missing", q0.size(), 0);
        chk(q1.size() == 0, "R12 channel 1 windows missing", q1.size(), 0);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule